// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave on a two-wire serial management bus. It gives a bus controller write and read access to a small bank of 8-bit control registers, such as the enables of individual clock outputs. The clock and data lines are sampled by the block's own clock. The slave pulls the data line low through an open-drain enable. The whole register bank is driven onto a flat parallel bus, so the logic it controls sees every register at all times.

A transaction starts with the device address byte. A command byte follows. Bit 7 of the command picks the access mode. With bit 7 at 1, the access is to one register, and bits 6:0 give its offset. With bit 7 at 0, the access is a sequential block that starts at register 0. In a block transfer, the first data byte is a byte count. Reads use a repeated START followed by the read form of the address. Clock stretching, packet error checking, bus timeouts and alerts are not part of this block.

Top module: `smb_regfile_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0x69 (byte D2h to write, D3h to read). Any other address byte gets no acknowledge and changes no register.
- R2: The slave acknowledges, by pulling SDA low during the ninth clock, the matching address byte, the command byte and every byte the controller writes.
- R3: A command byte with bit 7 set selects single-register mode, and bits 6:0 give the register offset. The following data byte is stored in that register.
- R4: In single-register mode, a repeated START with address byte D3h returns the register at the commanded offset, most significant bit first.
- R5: A command byte with bit 7 clear selects block mode starting at register 0. On a write, the first data byte is a count and is discarded. Each later byte goes to the next register in ascending order.
- R6: When the controller ends a block write with STOP after any whole byte, every byte already acknowledged stays stored and the remaining registers keep their values.
- R7: A block read returns the number of implemented registers first, and then registers 0, 1, 2 and onward, in ascending order.
- R8: When the controller does not acknowledge a read byte, the slave stops driving SDA and sends no further data.
- R9: A write to an offset at or above the register count is acknowledged and discarded. A read from such an offset returns 0x00.
- R10: A START or STOP that arrives part way through a byte abandons that byte. No register changes, and a START begins a new address phase.
- R11: Reset (rst_n low at a clock edge) returns every register to the default value 0xFF and releases SDA.
- R12: Register i appears on reg_q bits [8i+7:8i] and changes only when a written byte is accepted for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| reg_q | output | NUM_REGS*8 | All registers side by side, register 0 in the low byte |

## Verification
A bit counter or phase that is off by one puts the acknowledge pulse in the wrong clock. The controller sees this at the next ninth clock as a missing acknowledge or a corrupted byte, within one byte time. A wrong pointer or a lost count flag shows on reg_q as soon as the byte is accepted: the data lands in a neighbouring register, or the count is stored. On reads, the same faults shift the whole returned sequence by one register. A stale drive enable shows up as SDA held low after a controller NACK. That shows within one SCL period, and the following STOP is then blocked.

// File: rtl/smb_regs_pkg.sv
// Package: shared types of the two-wire register slave.
// Assumes: one slave instance per bus, 8-bit data bytes.
package smb_regs_pkg;

    // Bit-level state of the serial engine
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, ignore bits
        ST_RX,     // shifting a byte in from the controller
        ST_ACK,    // driving the acknowledge bit
        ST_TX,     // shifting a byte out to the controller
        ST_MACK    // waiting for the controller's acknowledge
    } smb_state_e;

    // Which byte of the transaction is being received
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_DATA
    } smb_phase_e;

endpackage

// File: rtl/smb_line_sync.sv
// Module: smb_line_sync
// Brings SCL and SDA into the clk domain and derives edge and bus-condition
// events from them. Both lines go through the same number of stages, so their
// relative timing is kept. Assumes the lines change much slower than clk.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[STAGES-2:0], sda_i};
            scl_d  <= scl_sr[STAGES-1];
            sda_d  <= sda_sr[STAGES-1];
        end
    end

    // Edge and START/STOP decode on the synchronized levels
    always_comb begin
        scl_s     = scl_sr[STAGES-1];
        sda_s     = sda_sr[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/smb_reg_bank.sv
// Module: smb_reg_bank
// Bank of 8-bit control registers with one write port and one combinational
// read port. Reads past the last register return zero. Assumes the caller
// only raises wr_en for an implemented index.
module smb_reg_bank #(
    parameter int          NUM_REGS    = 8,
    parameter int          IDX_W       = 7,
    parameter logic [7:0]  REG_DEFAULT = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] reg_q
);

    localparam logic [IDX_W:0] REG_CNT = (IDX_W+1)'(NUM_REGS);

    logic [7:0] mem [NUM_REGS];

    // Register storage: defaults on reset, single indexed write otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= REG_DEFAULT;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++)
                if ({1'b0, wr_idx} == (IDX_W+1)'(i)) mem[i] <= wr_data;
        end
    end

    // Read mux, zero for unimplemented offsets
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if ({1'b0, rd_idx} == (IDX_W+1)'(i)) rd_data = mem[i];
    end

    // Flatten the bank onto the parallel output
    for (genvar g = 0; g < NUM_REGS; g++) begin : gen_flat
        assign reg_q[g*8 +: 8] = mem[g];
    end

    // R9
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < REG_CNT));

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_q));

endmodule

// File: rtl/smb_regfile_slave.sv
// Module: smb_regfile_slave (top)
// Two-wire bus slave in front of a control register bank. It decodes the
// address, the command and the data bytes, and sends register bytes on reads.
// A command with bit 7 set accesses one register at the offset in bits 6:0.
// A command with bit 7 clear starts a block at offset 0, led by a count byte.
// Assumes SCL and SDA are oversampled by clk (several clk per SCL phase) and
// that the controller never stretches the clock.
module smb_regfile_slave
    import smb_regs_pkg::*;
#(
    parameter int          NUM_REGS    = 8,
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  REG_DEFAULT = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_q
);

    localparam int         OFS_W   = 7;
    localparam logic [7:0] REG_CNT = 8'(NUM_REGS);

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    smb_state_e       state;
    smb_phase_e       phase;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sr;
    logic [7:0]       tx_sr;
    logic [OFS_W-1:0] ptr;
    logic [OFS_W-1:0] ptr_inc;
    logic             ptr_hit;
    logic             count_pend;
    logic             is_read;
    logic             mack_ok;
    logic             sda_oe_q;
    logic             byte_done;
    logic             load_now;
    logic [7:0]       load_val;
    logic             wr_en;
    logic [7:0]       rd_data;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    smb_reg_bank #(
        .NUM_REGS    (NUM_REGS),
        .IDX_W       (OFS_W),
        .REG_DEFAULT (REG_DEFAULT)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ptr),
        .wr_data (rx_sr),
        .rd_idx  (ptr),
        .rd_data (rd_data),
        .reg_q   (reg_q)
    );

    // Pointer arithmetic, byte completion, read-byte load and write strobe
    always_comb begin
        ptr_inc   = (ptr == '1) ? ptr : ptr + 1'b1;
        ptr_hit   = ({1'b0, ptr} < REG_CNT);
        byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
        load_now  = ((state == ST_ACK) && scl_fall && (phase == PH_ADDR) && is_read) ||
                    ((state == ST_MACK) && scl_fall && mack_ok);
        load_val  = count_pend ? REG_CNT : rd_data;
        wr_en     = byte_done && (phase == PH_DATA) && !count_pend && ptr_hit;
    end

    // Serial protocol engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            phase      <= PH_ADDR;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            ptr        <= '0;
            count_pend <= 1'b0;
            is_read    <= 1'b0;
            mack_ok    <= 1'b0;
            sda_oe_q   <= 1'b0;
        end else if (start_evt) begin
            state    <= ST_RX;
            phase    <= PH_ADDR;
            bit_cnt  <= '0;
            sda_oe_q <= 1'b0;
        end else if (stop_evt) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            sda_oe_q <= 1'b0;
        end else if (load_now) begin
            tx_sr    <= load_val;
            sda_oe_q <= ~load_val[7];
            state    <= ST_TX;
            bit_cnt  <= '0;
            if (count_pend) count_pend <= 1'b0;
            else            ptr        <= ptr_inc;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        rx_sr   <= {rx_sr[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        case (phase)
                            PH_ADDR: begin
                                if (rx_sr[7:1] == DEV_ADDR) begin
                                    is_read  <= rx_sr[0];
                                    sda_oe_q <= 1'b1;
                                    state    <= ST_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            PH_CMD: begin
                                ptr        <= rx_sr[7] ? rx_sr[6:0] : '0;
                                count_pend <= ~rx_sr[7];
                                sda_oe_q   <= 1'b1;
                                state      <= ST_ACK;
                            end
                            default: begin
                                if (count_pend) count_pend <= 1'b0;
                                else            ptr        <= ptr_inc;
                                sda_oe_q <= 1'b1;
                                state    <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        sda_oe_q <= 1'b0;
                        state    <= ST_RX;
                        phase    <= (phase == PH_ADDR) ? PH_CMD : PH_DATA;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe_q <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ST_MACK;
                        end else begin
                            tx_sr    <= {tx_sr[6:0], 1'b0};
                            sda_oe_q <= ~tx_sr[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise)      mack_ok <= ~sda_s;
                    else if (scl_fall) state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = sda_oe_q;

    // R2
    ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK) |-> sda_oe);

    // R8
    drive_only_when_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ACK || state == ST_TX));

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_oe && state == ST_IDLE));

    // R10
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_RX && bit_cnt == 4'd0 && !sda_oe));

    // R5
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

    // R11
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);

endmodule

// File: tb/smb_regfile_slave_tb.sv
// Directed bench: a bus controller model drives SCL and SDA (open drain),
// and each scenario task checks its own results against a register model.
module smb_regfile_slave_tb;

    localparam int NREG = 8;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_scl = 1'b1;
    logic tb_sda_low = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] reg_q;
    wire  sda_line = ~(tb_sda_low | sda_oe);

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_regs [NREG];

    always #2.5 clk = ~clk;

    smb_regfile_slave #(.NUM_REGS(NREG)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (tb_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .reg_q  (reg_q)
    );

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NREG; i++)
            chk(req, $sformatf("reg%0d", i), 32'(reg_q[i*8 +: 8]), 32'(exp_regs[i]));
    endtask

    task automatic bus_start();
        tb_sda_low = 1'b0; wait_h();
        tb_scl = 1'b1;     wait_h();
        tb_sda_low = 1'b1; wait_h();
        tb_scl = 1'b0;     wait_h();
    endtask

    task automatic bus_stop();
        tb_sda_low = 1'b1; wait_h();
        tb_scl = 1'b1;     wait_h();
        tb_sda_low = 1'b0; wait_h();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            tb_sda_low = ~b[i]; wait_h();
            tb_scl = 1'b1;      wait_h();
            tb_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        tb_sda_low = 1'b0; wait_h();
        tb_scl = 1'b1; repeat (H/2) @(negedge clk);
        ack = ~sda_line; repeat (H/2) @(negedge clk);
        tb_scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        tb_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_h();
            tb_scl = 1'b1; repeat (H/2) @(negedge clk);
            b[i] = sda_line; repeat (H/2) @(negedge clk);
            tb_scl = 1'b0;
        end
        tb_sda_low = give_ack; wait_h();
        tb_scl = 1'b1; wait_h();
        tb_scl = 1'b0; wait_h();
    endtask

    task automatic t_reset();
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'hFF;
        chk("R11", "sda_oe after reset", 32'(sda_oe), 0);
        chk_regs("R11");
    endtask

    task automatic t_byte_write(input logic [6:0] off, input logic [7:0] val);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk("R1", "addr ack", 32'(a), 1);
        send_byte({1'b1, off}, a); chk("R2", "cmd ack", 32'(a), 1);
        send_byte(val, a); chk("R2", "data ack", 32'(a), 1);
        bus_stop();
        if (off < NREG) exp_regs[off] = val;
        chk_regs("R3");
    endtask

    task automatic t_byte_read(input logic [6:0] off, input logic [7:0] exp, input string req);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD2, a);
        send_byte({1'b1, off}, a);
        bus_start();
        send_byte(8'hD3, a); chk("R1", "read addr ack", 32'(a), 1);
        recv_byte(1'b0, d);
        chk(req, "byte read data", 32'(d), 32'(exp));
        chk("R8", "sda released after nack", 32'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte(8'hD4, a); chk("R1", "foreign addr nack", 32'(a), 0);
        send_byte(8'h81, a);
        send_byte(8'h00, a);
        bus_stop();
        chk_regs("R1");
    endtask

    task automatic t_block_write(input int cnt, input int nsend, input logic [7:0] base);
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'(cnt), a); chk("R5", "count ack", 32'(a), 1);
        for (int i = 0; i < nsend; i++) begin
            send_byte(base + 8'(i * 17), a);
            exp_regs[i] = base + 8'(i * 17);
        end
        bus_stop();
        chk_regs(nsend < cnt ? "R6" : "R5");
    endtask

    task automatic t_block_read(input int n);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, d); chk("R7", "block count", 32'(d), NREG);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1 ? 1'b0 : 1'b1, d);
            chk("R7", $sformatf("block byte %0d", i), 32'(d), 32'(exp_regs[i]));
        end
        chk("R8", "released after final nack", 32'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic t_out_of_range();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'hC0, a);
        send_byte(8'h99, a); chk("R9", "out of range write ack", 32'(a), 1);
        bus_stop();
        chk_regs("R9");
        t_byte_read(7'h40, 8'h00, "R9");
    endtask

    task automatic t_abort(input logic by_start);
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h82, a);
        send_bits(8'h3C, 5);
        if (by_start) begin
            bus_start();
            send_bits(8'h00, 3);
        end
        bus_stop();
        chk_regs("R10");
        t_byte_write(7'h2, 8'h5A);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_byte_write(7'h3, 8'hA5);
        t_byte_read(7'h3, 8'hA5, "R4");
        t_byte_write(7'h7, 8'h3C);
        t_byte_read(7'h7, 8'h3C, "R4");
        t_wrong_addr();
        t_block_write(3, 3, 8'h11);
        t_block_write(4, 2, 8'h44);
        t_block_read(4);
        t_out_of_range();
        t_abort(1'b1);
        t_abort(1'b0);
        t_block_read(NREG);
        t_reset_mid();
        t_byte_read(7'h0, 8'hFF, "R11");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule